// File: doc/BRIEF.md
# Two-Wire Bus Sync Pattern Detector

This block watches two bus lines, A and B, sampled by a system clock much faster than the bus. Each line goes through a two-flop synchroniser and an edge detector. The detector then finds the line sequences that open or control a transfer. When A is low while B is high, the detector becomes armed. It counts every falling edge of B while armed. On the next rising edge of A it classifies the count and reports the result as a one-cycle pulse carrying a pattern code.

A normal start or a start-with-CRC also raises `start_rx` for that one cycle, which tells a downstream byte receiver to begin. Occupancy, reset and frame-error reports do not raise `start_rx`. After any report the detector returns to the idle state and waits for the arming condition again.

The controller has two named states. IDLE moves to ARMED when synchronised A is low and synchronised B is high (transition "arm"). ARMED counts B falls and moves back to IDLE on a rise of A (transition "classify"), which emits the report. An active-low synchronous reset returns the block to IDLE and clears the edge count.

Top module: `sync_pattern_detector`

## Requirements
- R1: While reset is active and in the first cycles after it, `pattern_valid` and `start_rx` are 0 and `pattern_code` is 0.
- R2: No report is produced unless A was low while B was high. Toggling B while A stays high produces no pulse.
- R3: Exactly 4 B falls while armed, followed by an A rise with B high, reports code 1 (start) with `start_rx` = 1.
- R4: Exactly 6 B falls, then an A rise with B high, reports code 2 (start with CRC) with `start_rx` = 1.
- R5: Exactly 8 B falls, then an A rise with B high, reports code 3 (occupancy) with `start_rx` = 0.
- R6: 14 or more B falls, then an A rise with B high, reports code 4 (reset) with `start_rx` = 0.
- R7: Any other count at the A rise (such as 0, 5, 7 or 10) reports code 5 (frame error) with `start_rx` = 0.
- R8: If B is low when A rises, the report is code 5 (frame error) whatever the count.
- R9: `pattern_valid` lasts exactly one cycle per pattern. `pattern_code` is 0 whenever `pattern_valid` is 0.
- R10: After any report the detector re-arms, so back-to-back patterns are each reported once.
- R11: The fall counter saturates at 15. Twenty falls still report code 4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than the bus |
| rst_n | input | 1 | Active-low synchronous reset |
| line_a | input | 1 | Asynchronous sample of bus line A |
| line_b | input | 1 | Asynchronous sample of bus line B |
| pattern_valid | output | 1 | One-cycle pulse when a pattern is classified |
| pattern_code | output | 3 | 1 start, 2 start-with-CRC, 3 occupancy, 4 reset, 5 frame error, 0 when idle |
| start_rx | output | 1 | One-cycle pulse for the two start patterns only |

## Verification
The bench drives falling-edge counts of 0, 4, 5, 6, 7, 8, 10, 14 and 20 while A is low. These counts separate the exact-match classes from their neighbours, and they show that everything at 14 and above, including counts past saturation, maps to reset. A 4-fall sequence that leaves B low at the A rise shows that the level of B overrides the count. B toggling while A stays high shows that arming needs both conditions. Two patterns sent back to back show that the detector re-arms after each report.

// File: rtl/sync_pat_pkg.sv
package sync_pat_pkg;
    typedef enum logic [2:0] {
        PAT_NONE      = 3'd0,
        PAT_START     = 3'd1,
        PAT_START_CRC = 3'd2,
        PAT_OCCUPY    = 3'd3,
        PAT_RESET     = 3'd4,
        PAT_FRAME_ERR = 3'd5
    } pat_code_e;

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_ARMED = 1'b1
    } det_state_e;
endpackage

// File: rtl/line_sync.sv
module line_sync #(
    parameter int N_LINES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_LINES-1:0] din,
    output logic [N_LINES-1:0] level,
    output logic [N_LINES-1:0] rise,
    output logic [N_LINES-1:0] fall
);
    logic [N_LINES-1:0] meta_q;
    logic [N_LINES-1:0] sync_q;
    logic [N_LINES-1:0] prev_q;

    for (genvar i = 0; i < N_LINES; i++) begin : g_line
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                meta_q[i] <= 1'b1;
                sync_q[i] <= 1'b1;
                prev_q[i] <= 1'b1;
            end else begin
                meta_q[i] <= din[i];
                sync_q[i] <= meta_q[i];
                prev_q[i] <= sync_q[i];
            end
        end
        assign level[i] = sync_q[i];
        assign rise[i]  = sync_q[i] & ~prev_q[i];
        assign fall[i]  = ~sync_q[i] & prev_q[i];
    end
endmodule

// File: rtl/edge_counter.sv
module edge_counter #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             inc,
    output logic [CNT_W-1:0] cnt
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt <= '0;
        end else if (inc && cnt != CNT_MAX) begin
            cnt <= cnt + 1'b1;
        end
    end

    p_cnt_sat_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == CNT_MAX && !clr) |=> (cnt == CNT_MAX || $past(clr)));
endmodule

// File: rtl/sync_pattern_detector.sv
module sync_pattern_detector
    import sync_pat_pkg::*;
#(
    parameter int CNT_W         = 4,
    parameter int CNT_START     = 4,
    parameter int CNT_START_CRC = 6,
    parameter int CNT_OCCUPY    = 8,
    parameter int CNT_RESET_MIN = 14
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       line_a,
    input  logic       line_b,
    output logic       pattern_valid,
    output logic [2:0] pattern_code,
    output logic       start_rx
);
    localparam int IDX_A = 0;
    localparam int IDX_B = 1;

    logic [1:0]       lvl, rise, fall;
    logic [CNT_W-1:0] fall_cnt;
    det_state_e       state, state_nxt;
    pat_code_e        class_code;
    logic             report;

    line_sync #(.N_LINES(2)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   ({line_b, line_a}),
        .level (lvl),
        .rise  (rise),
        .fall  (fall)
    );

    edge_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (state == ST_IDLE),
        .inc   (state == ST_ARMED && fall[IDX_B]),
        .cnt   (fall_cnt)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nxt;
    end

    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_IDLE:  if (!lvl[IDX_A] && lvl[IDX_B]) state_nxt = ST_ARMED;
            ST_ARMED: if (rise[IDX_A])               state_nxt = ST_IDLE;
            default:                                 state_nxt = ST_IDLE;
        endcase
    end

    assign report = (state == ST_ARMED) && rise[IDX_A];

    // Classification of the count at the A rise
    always_comb begin
        if (!lvl[IDX_B])                          class_code = PAT_FRAME_ERR;
        else if (int'(fall_cnt) == CNT_START)     class_code = PAT_START;
        else if (int'(fall_cnt) == CNT_START_CRC) class_code = PAT_START_CRC;
        else if (int'(fall_cnt) == CNT_OCCUPY)    class_code = PAT_OCCUPY;
        else if (int'(fall_cnt) >= CNT_RESET_MIN) class_code = PAT_RESET;
        else                                      class_code = PAT_FRAME_ERR;
    end

    // Output register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pattern_valid <= 1'b0;
            pattern_code  <= PAT_NONE;
            start_rx      <= 1'b0;
        end else begin
            pattern_valid <= report;
            pattern_code  <= report ? class_code : PAT_NONE;
            start_rx      <= report && (class_code == PAT_START ||
                                        class_code == PAT_START_CRC);
        end
    end

    p_valid_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        pattern_valid |=> !pattern_valid);
    p_code_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !pattern_valid |-> pattern_code == 3'd0);
    p_rx_start_only_r3: assert property (@(posedge clk) disable iff (!rst_n)
        start_rx |-> pattern_valid && (pattern_code == 3'd1 || pattern_code == 3'd2));
    p_no_rx_occupy_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (pattern_valid && pattern_code >= 3'd3) |-> !start_rx);
    p_arm_cond_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ARMED && $past(state) == ST_IDLE) |-> $past(!lvl[IDX_A] && lvl[IDX_B]));
    p_rearm_r10: assert property (@(posedge clk) disable iff (!rst_n)
        report |=> state == ST_IDLE);
endmodule

// File: tb/sync_pattern_detector_tb.sv
module sync_pattern_detector_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       line_a = 1'b1;
    logic       line_b = 1'b1;
    logic       pattern_valid;
    logic [2:0] pattern_code;
    logic       start_rx;

    int n_checks = 0;
    int n_fail   = 0;
    int pulses   = 0;
    int cycles   = 0;
    logic [2:0] last_code = 3'd0;
    logic       saw_rx = 1'b0;
    logic       long_pulse = 1'b0;
    logic       prev_valid = 1'b0;
    logic       bad_idle_code = 1'b0;

    always #5 clk = ~clk;

    sync_pattern_detector u_dut (
        .clk(clk), .rst_n(rst_n), .line_a(line_a), .line_b(line_b),
        .pattern_valid(pattern_valid), .pattern_code(pattern_code), .start_rx(start_rx)
    );

    always @(negedge clk) begin
        cycles <= cycles + 1;
        if (rst_n) begin
            if (pattern_valid) begin
                pulses    <= pulses + 1;
                last_code <= pattern_code;
                if (prev_valid) long_pulse <= 1'b1;
            end else if (pattern_code != 3'd0) begin
                bad_idle_code <= 1'b1;
            end
            if (start_rx) saw_rx <= 1'b1;
            prev_valid <= pattern_valid;
        end
        if (cycles > 100000) begin
            n_fail++;
            $display("FAIL watchdog: run hung, actual cycles=%0d expected < 100000", cycles);
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic hold(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic clear_mon();
        @(negedge clk);
        pulses = 0; saw_rx = 1'b0; long_pulse = 1'b0; last_code = 3'd0;
    endtask

    // A low, n B falls, A high; b_end selects B level at the A rise
    task automatic send(input int n_falls, input bit b_end);
        line_a = 1'b0; hold(4);
        for (int i = 0; i < n_falls; i++) begin
            line_b = 1'b0; hold(4);
            if (i != n_falls - 1 || b_end) begin
                line_b = 1'b1; hold(4);
            end
        end
        line_a = 1'b1; hold(10);
        line_b = 1'b1; hold(6);
    endtask

    task automatic t_pattern(input string tag, input int n_falls, input bit b_end,
                             input int exp_code, input bit exp_rx);
        clear_mon();
        send(n_falls, b_end);
        @(negedge clk);
        check(pulses == 1, {tag, " pulse count"}, pulses, 1);
        check(last_code == 3'(exp_code), {tag, " code"}, last_code, exp_code);
        check(saw_rx == exp_rx, {tag, " start_rx"}, saw_rx, exp_rx);
        check(!long_pulse, {tag, " R9 pulse width"}, long_pulse, 0);
    endtask

    task automatic t_reset();
        hold(3);
        check(!pattern_valid && !start_rx && pattern_code == 3'd0, "R1 during reset",
              {pattern_valid, start_rx, pattern_code}, 0);
        rst_n = 1'b1; hold(4);
        check(!pattern_valid && !start_rx && pattern_code == 3'd0, "R1 after reset",
              {pattern_valid, start_rx, pattern_code}, 0);
    endtask

    task automatic t_no_arm();
        clear_mon();
        for (int i = 0; i < 5; i++) begin
            line_b = 1'b0; hold(4); line_b = 1'b1; hold(4);
        end
        hold(10);
        check(pulses == 0, "R2 B toggles with A high", pulses, 0);
    endtask

    task automatic t_back_to_back();
        clear_mon();
        send(4, 1'b1);
        send(8, 1'b1);
        @(negedge clk);
        check(pulses == 2, "R10 two patterns reported", pulses, 2);
        check(last_code == 3'd3, "R10 second code", last_code, 3);
    endtask

    initial begin
        t_reset();
        t_no_arm();
        t_pattern("R3 start",         4,  1'b1, 1, 1'b1);
        t_pattern("R4 start crc",     6,  1'b1, 2, 1'b1);
        t_pattern("R5 occupancy",     8,  1'b1, 3, 1'b0);
        t_pattern("R6 reset 14",      14, 1'b1, 4, 1'b0);
        t_pattern("R11 reset sat 20", 20, 1'b1, 4, 1'b0);
        t_pattern("R7 count 0",       0,  1'b1, 5, 1'b0);
        t_pattern("R7 count 5",       5,  1'b1, 5, 1'b0);
        t_pattern("R7 count 7",       7,  1'b1, 5, 1'b0);
        t_pattern("R7 count 10",      10, 1'b1, 5, 1'b0);
        t_pattern("R8 B low at rise", 4,  1'b0, 5, 1'b0);
        t_back_to_back();
        check(!bad_idle_code, "R9 code zero when idle", bad_idle_code, 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule